// File: doc/BRIEF.md
# Multi-Level Translation Lookup Hit Comparator

This block holds a small set of fully associative address translation entries and answers, for a presented virtual page number and address-space identifier, which entries cover that page. The virtual page number is split into equal fields, one per page level. Level 0 is a 4KB page, and each higher level makes one more low field irrelevant. With the default geometry the higher levels are 2MB, 1GB and 512GB pages. A level-0 entry can also be marked as a naturally aligned 64KB page. That case is treated as a level-0 entry whose four lowest tag bits are left out of the comparison.

Entries are loaded through a single write port that addresses one entry at a time. A flush input invalidates every entry in one cycle. A lookup is registered. One cycle after the request, the block presents four outputs: a per-entry hit vector, the index of the lowest hitting entry, an any-hit flag, and a flag that is raised when more than one entry hits. Replacement choice, permission checking and physical page formation belong to the surrounding logic.

Top module: `tlb_hit_cmp`

## Requirements
- R1: After synchronous reset every entry is invalid, and hit_vec, hit_idx, hit_any and multi_hit are all zero.
- R2: For a level-0 entry (wr_level = 0) without the 64KB flag, all VPN bits take part in the comparison. A difference in any one bit makes it miss.
- R3: An entry of level L (wr_level = L, with 0 = 4KB, 1 = 2MB, 2 = 1GB, 3 = 512GB) leaves the lowest 9*L VPN bits out of the comparison and compares every bit above them.
- R4: A level-0 entry with the 64KB flag set (wr_napot = 1) ignores VPN bits 3..0 and compares bits 4 and upward.
- R5: An entry whose global flag is set matches any lookup ASID. Otherwise the lookup ASID must equal the stored ASID.
- R6: An invalid entry never hits. A flush clears all entries in one cycle, and a write issued in the same cycle as a flush is dropped.
- R7: hit_idx is the lowest index whose hit_vec bit is set, or 0 when there is no hit. hit_any is set when any bit of hit_vec is set. multi_hit is set when two or more bits of hit_vec are set.
- R8: The outputs reflect the lookup presented in the previous cycle, taken against the entry contents in that cycle. A write takes effect for lookups from the following cycle.
- R9: In the cycle after a cycle in which lk_req is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 3 | Entry to load |
| wr_vpn | input | 36 | Tag to store |
| wr_asid | input | 16 | Address-space ID to store |
| wr_level | input | 2 | Page level to store (0..3) |
| wr_napot | input | 1 | Mark entry as a 64KB page |
| wr_global | input | 1 | Entry matches every ASID |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_asid | input | 16 | Lookup address-space ID |
| hit_vec | output | 8 | Registered per-entry hit bits |
| hit_idx | output | 3 | Registered lowest hitting index |
| hit_any | output | 1 | Registered any-hit flag |
| multi_hit | output | 1 | Registered more-than-one-hit flag |

## Verification
The main comparison is swept one bit at a time. For each of the four levels, and for the 64KB variant, a single entry is loaded and probed with the exact tag and then with each of the 36 single-bit flips of that tag. These sweeps locate the edge of the ignored region exactly, so they separate an off-by-one field boundary and a missing 64KB mask from a correct mask. ASID probes with the global flag cleared and then set separate ASID gating from tag matching. Overlapping entries at separated indices check the choice of the lowest index and the multi-hit flag. Cases that put a write and a lookup in the same cycle, and a write and a flush in the same cycle, check the ordering rules.

// File: rtl/tlbhc_pkg.sv
package tlbhc_pkg;
  localparam int unsigned DEF_ENTRIES    = 8;
  localparam int unsigned DEF_LEVELS     = 4;
  localparam int unsigned DEF_LVL_BITS   = 9;
  localparam int unsigned DEF_NAPOT_BITS = 4;
  localparam int unsigned DEF_ASID_W     = 16;
endpackage

// File: rtl/tlbhc_store.sv
module tlbhc_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 36,
  parameter int unsigned ASID_W  = 16,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             flush,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [VPN_W-1:0]                 wr_vpn,
  input  logic [ASID_W-1:0]                wr_asid,
  input  logic [LVL_W-1:0]                 wr_level,
  input  logic                             wr_napot,
  input  logic                             wr_global,
  output logic [ENTRIES-1:0]               e_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]    e_vpn,
  output logic [ENTRIES-1:0][ASID_W-1:0]   e_asid,
  output logic [ENTRIES-1:0][LVL_W-1:0]    e_level,
  output logic [ENTRIES-1:0]               e_napot,
  output logic [ENTRIES-1:0]               e_global
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && !flush && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || flush) e_valid[i] <= 1'b0;
      else if (sel)     e_valid[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        e_vpn[i]    <= wr_vpn;
        e_asid[i]   <= wr_asid;
        e_level[i]  <= wr_level;
        e_napot[i]  <= wr_napot;
        e_global[i] <= wr_global;
      end
    end
  end
endmodule

// File: rtl/tlbhc_match.sv
module tlbhc_match #(
  parameter int unsigned VPN_W      = 36,
  parameter int unsigned ASID_W     = 16,
  parameter int unsigned LVL_W      = 2,
  parameter int unsigned LVL_BITS   = 9,
  parameter int unsigned NAPOT_BITS = 4
) (
  input  logic              ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [LVL_W-1:0]  ent_level,
  input  logic              ent_napot,
  input  logic              ent_global,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit
);
  logic [VPN_W-1:0] keep;
  logic             tag_ok;
  logic             asid_ok;

  // One shared mask: level fields first, then the 64KB low bits on top.
  always_comb begin
    for (int b = 0; b < VPN_W; b++) begin
      keep[b] = (b >= int'(LVL_BITS) * int'(ent_level)) &&
                !(ent_napot && (b < int'(NAPOT_BITS)));
    end
  end

  assign tag_ok  = ((ent_vpn ^ q_vpn) & keep) == '0;
  assign asid_ok = ent_global || (ent_asid == q_asid);
  assign hit     = ent_valid && tag_ok && asid_ok;
endmodule

// File: rtl/tlbhc_pick.sv
module tlbhc_pick #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vec,
  output logic [IDX_W-1:0]   idx,
  output logic               any,
  output logic               multi
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - {{(ENTRIES-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/tlb_hit_cmp.sv
module tlb_hit_cmp
  import tlbhc_pkg::*;
#(
  parameter int unsigned ENTRIES    = DEF_ENTRIES,
  parameter int unsigned LEVELS     = DEF_LEVELS,
  parameter int unsigned LVL_BITS   = DEF_LVL_BITS,
  parameter int unsigned NAPOT_BITS = DEF_NAPOT_BITS,
  parameter int unsigned ASID_W     = DEF_ASID_W,
  localparam int unsigned VPN_W     = LEVELS * LVL_BITS,
  localparam int unsigned LVL_W     = $clog2(LEVELS),
  localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [LVL_W-1:0]   wr_level,
  input  logic               wr_napot,
  input  logic               wr_global,
  input  logic               lk_req,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               hit_any,
  output logic               multi_hit
);
  logic [ENTRIES-1:0]             e_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][LVL_W-1:0]  e_level;
  logic [ENTRIES-1:0]             e_napot;
  logic [ENTRIES-1:0]             e_global;
  logic [ENTRIES-1:0]             raw_hit;
  logic [ENTRIES-1:0]             req_hit;
  logic [IDX_W-1:0]               pick_idx;
  logic                           pick_any;
  logic                           pick_multi;

  tlbhc_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_level(wr_level), .wr_napot(wr_napot), .wr_global(wr_global),
    .e_valid(e_valid), .e_vpn(e_vpn), .e_asid(e_asid),
    .e_level(e_level), .e_napot(e_napot), .e_global(e_global)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    tlbhc_match #(
      .VPN_W(VPN_W), .ASID_W(ASID_W), .LVL_W(LVL_W),
      .LVL_BITS(LVL_BITS), .NAPOT_BITS(NAPOT_BITS)
    ) u_match (
      .ent_valid(e_valid[i]), .ent_vpn(e_vpn[i]), .ent_asid(e_asid[i]),
      .ent_level(e_level[i]), .ent_napot(e_napot[i]),
      .ent_global(e_global[i]),
      .q_vpn(lk_vpn), .q_asid(lk_asid), .hit(raw_hit[i])
    );
  end

  assign req_hit = lk_req ? raw_hit : '0;

  tlbhc_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vec(req_hit), .idx(pick_idx), .any(pick_any), .multi(pick_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vec   <= '0;
      hit_idx   <= '0;
      hit_any   <= 1'b0;
      multi_hit <= 1'b0;
    end else begin
      hit_vec   <= req_hit;
      hit_idx   <= pick_idx;
      hit_any   <= pick_any;
      multi_hit <= pick_multi;
    end
  end
endmodule

// File: rtl/tlbhc_chk.sv
module tlbhc_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_req,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [IDX_W-1:0]   hit_idx,
  input logic               hit_any,
  input logic               multi_hit
);
  logic [ENTRIES-1:0] below;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) below[i] = (i < int'(hit_idx));
  end

  AST_ANY_FOLLOWS_VEC: assert property (@(posedge clk) disable iff (rst)
    hit_any == (hit_vec != '0)); // R7

  AST_MULTI_COUNT: assert property (@(posedge clk) disable iff (rst)
    multi_hit == ($countones(hit_vec) > 1)); // R7

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (hit_vec[hit_idx] && ((hit_vec & below) == '0))); // R7

  AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    !hit_any |-> (hit_idx == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> (hit_vec == '0 && !hit_any && !multi_hit)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (hit_vec == '0 && hit_idx == '0 && !hit_any && !multi_hit)); // R1
endmodule

bind tlb_hit_cmp tlbhc_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_req(lk_req), .hit_vec(hit_vec),
  .hit_idx(hit_idx), .hit_any(hit_any), .multi_hit(multi_hit)
);

// File: tb/tb_tlb_hit_cmp.sv
module tb_tlb_hit_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int VW = 36;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [VW-1:0] wr_vpn = '0;
  logic [AW-1:0] wr_asid = '0;
  logic [1:0]    wr_level = '0;
  logic          wr_napot = 1'b0;
  logic          wr_global = 1'b0;
  logic          lk_req = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic [N-1:0]  hit_vec;
  logic [IW-1:0] hit_idx;
  logic          hit_any;
  logic          multi_hit;

  int tests = 0;
  int fails = 0;

  logic          m_valid [N];
  logic [VW-1:0] m_vpn   [N];
  logic [AW-1:0] m_asid  [N];
  int            m_lvl   [N];
  logic          m_napot [N];
  logic          m_glob  [N];

  tlb_hit_cmp dut (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_level(wr_level),
    .wr_napot(wr_napot), .wr_global(wr_global), .lk_req(lk_req),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .hit_vec(hit_vec),
    .hit_idx(hit_idx), .hit_any(hit_any), .multi_hit(multi_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [N-1:0] model_vec(logic [VW-1:0] v, logic [AW-1:0] a);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      logic ok = m_valid[i] && (m_glob[i] || m_asid[i] == a);
      for (int b = 0; b < VW; b++) begin
        if (b >= 9 * m_lvl[i] && !(m_napot[i] && b < 4) && m_vpn[i][b] != v[b]) ok = 1'b0;
      end
      r[i] = ok;
    end
    return r;
  endfunction

  task automatic check_out(string req, logic [N-1:0] ev);
    logic [IW-1:0] ei = '0;
    logic ea = |ev;
    logic em = ($countones(ev) > 1);
    for (int i = N - 1; i >= 0; i--) if (ev[i]) ei = IW'(i);
    tests++;
    if (hit_vec !== ev || hit_idx !== ei || hit_any !== ea || multi_hit !== em) begin
      fails++;
      $display("FAIL %s: actual vec=%b idx=%0d any=%b multi=%b expected vec=%b idx=%0d any=%b multi=%b",
               req, hit_vec, hit_idx, hit_any, multi_hit, ev, ei, ea, em);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    clear_model();
  endtask

  task automatic drive_write(int idx, logic [VW-1:0] v, logic [AW-1:0] a, int l, logic np, logic g);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = v; wr_asid = a;
    wr_level = 2'(l); wr_napot = np; wr_global = g;
  endtask

  task automatic model_write(int idx, logic [VW-1:0] v, logic [AW-1:0] a, int l, logic np, logic g);
    m_valid[idx] = 1'b1; m_vpn[idx] = v; m_asid[idx] = a;
    m_lvl[idx] = l; m_napot[idx] = np; m_glob[idx] = g;
  endtask

  task automatic do_write(int idx, logic [VW-1:0] v, logic [AW-1:0] a, int l, logic np, logic g);
    @(negedge clk);
    drive_write(idx, v, a, l, np, g);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, v, a, l, np, g);
  endtask

  task automatic probe(string req, logic [VW-1:0] v, logic [AW-1:0] a);
    logic [N-1:0] ev;
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_asid = a;
    ev = model_vec(v, a);
    @(negedge clk);
    lk_req = 1'b0;
    check_out(req, ev);
  endtask

  localparam logic [VW-1:0] BASE = 36'hA5C37E1B9;
  localparam logic [AW-1:0] ASID = 16'h1234;

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_out("R1 reset outputs", '0);
    probe("R1 R6 no valid entry after reset", '0, '0);

    // Per-level single-bit flip sweeps: levels 0..3 and the 64KB variant.
    for (int cfg = 0; cfg < 5; cfg++) begin
      int l = (cfg < 4) ? cfg : 0;
      logic np = (cfg == 4);
      string tag = (cfg == 0) ? "R2 level0" : (cfg == 4) ? "R4 napot" : "R3 level";
      do_flush();
      do_write(3, BASE, ASID, l, np, 1'b0);
      probe(tag, BASE, ASID);
      for (int b = 0; b < VW; b++) begin
        probe(tag, BASE ^ (36'd1 << b), ASID);
      end
    end

    // ASID gating.
    do_flush();
    do_write(1, BASE, ASID, 2, 1'b0, 1'b0);
    probe("R5 asid equal", BASE, ASID);
    probe("R5 asid differs", BASE, ASID ^ 16'h0001);
    do_write(1, BASE, ASID, 2, 1'b0, 1'b1);
    probe("R5 global any asid", BASE, 16'hBEEF);

    // Several hitting entries.
    do_flush();
    do_write(5, BASE, ASID, 1, 1'b0, 1'b0);
    do_write(2, BASE ^ 36'h0000000FF, ASID, 1, 1'b0, 1'b0);
    do_write(6, BASE ^ 36'h100000000, ASID, 3, 1'b0, 1'b1);
    do_write(7, BASE, ASID, 0, 1'b1, 1'b0);
    probe("R7 multi lowest index", BASE, ASID);
    probe("R7 single high index", BASE ^ 36'h100000000, ASID);
    probe("R7 miss index zero", ~BASE, ASID);

    // Idle cycle after a hit.
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = BASE; lk_asid = ASID;
    @(negedge clk);
    check_out("R7 hit before idle", model_vec(BASE, ASID));
    lk_req = 1'b0;
    @(negedge clk);
    check_out("R9 idle outputs zero", '0);

    // Write and lookup in the same cycle.
    do_flush();
    @(negedge clk);
    drive_write(0, BASE, ASID, 0, 1'b0, 1'b0);
    lk_req = 1'b1; lk_vpn = BASE; lk_asid = ASID;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    check_out("R8 same-cycle lookup sees old", '0);
    model_write(0, BASE, ASID, 0, 1'b0, 1'b0);
    probe("R8 next-cycle lookup sees write", BASE, ASID);

    // Flush together with a write drops the write; flush clears entries.
    @(negedge clk);
    drive_write(4, ~BASE, ASID, 0, 1'b0, 1'b0);
    flush = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flush = 1'b0;
    clear_model();
    probe("R6 write dropped under flush", ~BASE, ASID);
    probe("R6 flush cleared entry", BASE, ASID);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule